// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block takes 16-bit command words from a three-wire serial link and keeps the settings of a voltage-output converter: an 8-bit output code and a 2-bit output-state mode. The link has an active-low select line, a serial clock and a data line. A command starts when select falls. The data line is sampled on each falling serial clock edge, most significant bit first. The command takes effect on the sixteenth falling edge, without waiting for select to rise. A complete command produces a one-cycle update strobe. The mode is also decoded into four mutually exclusive controls for the analog output stage: driven, pulled down through 1k, pulled down through 100k, or floating.

All three serial lines are sampled by the system clock through two-flop synchronizers, and edges are found from the synchronized levels. Each line is therefore limited to a toggle rate well below the system clock. The receiver is a three-state machine. `RX_IDLE` waits for a select falling edge and leaves to `RX_SHIFT` on that edge. `RX_SHIFT` counts serial clock falls. It goes back to `RX_IDLE` if select rises early (abort). It moves to `RX_HOLD` on the sixteenth fall (complete). `RX_HOLD` ignores every serial clock edge and goes back to `RX_IDLE` once select is high (re-arm).

Top module: `sdac_cmd_rx`

## Requirements
- R1: After reset the output code is 0, the mode is 00, only the driven control is active and the update strobe is low.
- R2: A command begins only on a falling edge of the select line that follows a period with select high.
- R3: Bits are taken on falling serial clock edges, most significant first. In the 16-bit word, bits 13:12 are the mode and bits 11:4 are the output code.
- R4: The command is applied on the sixteenth falling edge while select is still low, and `upd_pulse` is high for exactly one system clock cycle. Outside a complete command, the code and mode do not change.
- R5: Mode decode is 00 driven, 01 1k pulldown, 10 100k pulldown, 11 floating. Exactly one of the four controls is active at any time.
- R6: If select goes high before the sixteenth falling edge, the partial command is discarded. Neither the code nor the mode changes and no strobe is issued.
- R7: Serial clock falls after the sixteenth, with select still low, are ignored until select goes high and falls again.
- R8: Bits 15:14 and 3:0 of the word have no effect.
- R9: The code is straight binary. Every value from 0 to 255 appears unchanged on `dac_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_in | input | 1 | Active-low command select, asynchronous |
| sck_in | input | 1 | Serial clock, asynchronous |
| sdi_in | input | 1 | Serial data, asynchronous |
| dac_code | output | 8 | Current output code |
| pd_mode | output | 2 | Current output-state mode |
| drv_normal | output | 1 | Output buffer drives the pin |
| drv_pull1k | output | 1 | Pin pulled to ground through 1k |
| drv_pull100k | output | 1 | Pin pulled to ground through 100k |
| drv_hiz | output | 1 | Pin left floating |
| upd_pulse | output | 1 | One-cycle strobe when a command is applied |

## Verification
The hardest case to reach is the hold state: sixteen bits have been taken, select is still low, and more serial clocks arrive. A port-level stimulus produces it only when a complete word is followed by a second word that carries different data, with no re-arm in between. The stimulus sends exactly that second word. It then checks that the code, the mode and the strobe count keep the values of the first word, and that a fresh select cycle afterwards is accepted. An aborted ten-bit word and words with the ignored bits set are also sent, and the outputs are checked to stay as the requirements say.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    localparam int FRAME_W  = 16;
    localparam int CODE_W   = 8;
    localparam int MODE_W   = 2;
    localparam int CODE_LSB = 4;
    localparam int MODE_LSB = 12;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_HOLD  = 2'd2
    } rx_state_t;

    typedef enum logic [1:0] {
        PD_DRIVE    = 2'b00,
        PD_PULL1K   = 2'b01,
        PD_PULL100K = 2'b10,
        PD_FLOAT    = 2'b11
    } pd_mode_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic lvl,
    output logic rise,
    output logic fall
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {DEPTH{RST_VAL}};
        end else begin
            chain <= {chain[DEPTH-2:0], d};
        end
    end

    // chain[STAGES-1] is the synchronized level, chain[STAGES] the one before
    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~chain[STAGES];
    assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/sdac_frame_fsm.sv
module sdac_frame_fsm
    import sdac_pkg::*;
#(
    parameter int WORD_W = FRAME_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_lvl,
    input  logic              sel_fall,
    input  logic              sck_fall,
    input  logic              sdi_lvl,
    output logic [WORD_W-1:0] frame_q,
    output logic              frame_vld
);
    localparam int                CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(WORD_W - 1);

    rx_state_t        state, state_nx;
    logic [CNT_W-1:0] bit_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions: start, abort, complete, re-arm
    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE: begin
                if (sel_fall) state_nx = RX_SHIFT;
            end
            RX_SHIFT: begin
                if (sel_lvl)                          state_nx = RX_IDLE;
                else if (sck_fall && bit_cnt == LAST) state_nx = RX_HOLD;
            end
            RX_HOLD: begin
                if (sel_lvl) state_nx = RX_IDLE;
            end
            default: state_nx = RX_IDLE;
        endcase
    end

    // datapath / outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q   <= '0;
            bit_cnt   <= '0;
            frame_vld <= 1'b0;
        end else begin
            frame_vld <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    bit_cnt <= '0;
                end
                RX_SHIFT: begin
                    if (!sel_lvl && sck_fall) begin
                        frame_q <= {frame_q[WORD_W-2:0], sdi_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == LAST) frame_vld <= 1'b1;
                    end
                end
                RX_HOLD: begin
                    bit_cnt <= '0;
                end
                default: begin
                    bit_cnt <= '0;
                end
            endcase
        end
    end

    // R4: a completed word is flagged only on entry into the hold state
    a_r4_vld_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |-> (state == RX_HOLD));

    // R6: an early select rise returns to idle without flagging a word
    a_r6_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_SHIFT && sel_lvl) |=> (state == RX_IDLE && !frame_vld));

    // R7: once held, further serial clocks produce no new word
    a_r7_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_HOLD && sck_fall && !sel_lvl) |=> (state == RX_HOLD && !frame_vld));

    // R2: idle is left only on a select falling edge
    a_r2_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && !sel_fall) |=> (state == RX_IDLE));
endmodule

// File: rtl/sdac_cmd_regs.sv
module sdac_cmd_regs
    import sdac_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int MW = MODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [CW-1:0] code_in,
    input  logic [MW-1:0] mode_in,
    output logic [CW-1:0] code_q,
    output logic [MW-1:0] mode_q,
    output logic          upd_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            mode_q <= '0;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= commit;
            if (commit) begin
                code_q <= code_in;
                mode_q <= mode_in;
            end
        end
    end

    // R4: settings move only after a commit
    a_r4_hold_settings: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(code_q) && $stable(mode_q)));

    // R4: the strobe never lasts two cycles
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        upd_q |=> !upd_q);
endmodule

// File: rtl/sdac_pd_decode.sv
module sdac_pd_decode
    import sdac_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output logic              drive,
    output logic              pull1k,
    output logic              pull100k,
    output logic              float_o
);
    always_comb begin
        drive    = 1'b0;
        pull1k   = 1'b0;
        pull100k = 1'b0;
        float_o  = 1'b0;
        unique case (pd_mode_t'(mode))
            PD_DRIVE:    drive    = 1'b1;
            PD_PULL1K:   pull1k   = 1'b1;
            PD_PULL100K: pull100k = 1'b1;
            PD_FLOAT:    float_o  = 1'b1;
            default:     drive    = 1'b1;
        endcase
    end
endmodule

// File: rtl/sdac_cmd_rx.sv
module sdac_cmd_rx
    import sdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_in,
    input  logic              sck_in,
    input  logic              sdi_in,
    output logic [CODE_W-1:0] dac_code,
    output logic [MODE_W-1:0] pd_mode,
    output logic              drv_normal,
    output logic              drv_pull1k,
    output logic              drv_pull100k,
    output logic              drv_hiz,
    output logic              upd_pulse
);
    localparam int         NLINES   = 3;
    localparam logic [2:0] LINE_RST = 3'b011; // [0] select, [1] clock idle high, [2] data

    logic [NLINES-1:0] raw, lvl, rise, fall;
    logic [FRAME_W-1:0] frame_q;
    logic               frame_vld;
    logic               unused_sig;

    assign raw = {sdi_in, sck_in, sel_n_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        sdac_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(LINE_RST[g])
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw[g]),
            .lvl  (lvl[g]),
            .rise (rise[g]),
            .fall (fall[g])
        );
    end

    assign unused_sig = ^{rise, fall[2], frame_q};

    sdac_frame_fsm #(.WORD_W(FRAME_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_lvl  (lvl[0]),
        .sel_fall (fall[0]),
        .sck_fall (fall[1]),
        .sdi_lvl  (lvl[2]),
        .frame_q  (frame_q),
        .frame_vld(frame_vld)
    );

    sdac_cmd_regs #(.CW(CODE_W), .MW(MODE_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (frame_vld),
        .code_in(frame_q[CODE_LSB +: CODE_W]),
        .mode_in(frame_q[MODE_LSB +: MODE_W]),
        .code_q (dac_code),
        .mode_q (pd_mode),
        .upd_q  (upd_pulse)
    );

    sdac_pd_decode u_dec (
        .mode    (pd_mode),
        .drive   (drv_normal),
        .pull1k  (drv_pull1k),
        .pull100k(drv_pull100k),
        .float_o (drv_hiz)
    );

    // R5: exactly one output-stage control is active
    a_r5_one_control: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({drv_normal, drv_pull1k, drv_pull100k, drv_hiz}) == 1);
endmodule

// File: tb/sdac_cmd_rx_bench.sv
module sdac_cmd_rx_bench;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n, sel_n, sck, sdi;
    logic [7:0] dac_code;
    logic [1:0] pd_mode;
    logic       drv_normal, drv_pull1k, drv_pull100k, drv_hiz, upd_pulse;

    int total = 0;
    int bad   = 0;
    int pulses = 0;
    int pushed = 0;

    typedef struct packed {
        logic [7:0] code;
        logic [1:0] mode;
    } exp_t;
    exp_t expq[$];

    sdac_cmd_rx u_sdac_cmd_rx (
        .clk(clk), .rst_n(rst_n), .sel_n_in(sel_n), .sck_in(sck), .sdi_in(sdi),
        .dac_code(dac_code), .pd_mode(pd_mode), .drv_normal(drv_normal),
        .drv_pull1k(drv_pull1k), .drv_pull100k(drv_pull100k), .drv_hiz(drv_hiz),
        .upd_pulse(upd_pulse)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [3:0] drv_of(input logic [1:0] m);
        case (m)
            2'b00:   return 4'b0001;
            2'b01:   return 4'b0010;
            2'b10:   return 4'b0100;
            default: return 4'b1000;
        endcase
    endfunction

    function automatic logic [3:0] drv_now();
        return {drv_hiz, drv_pull100k, drv_pull1k, drv_normal};
    endfunction

    // monitor: compare every applied command with the scoreboard
    always @(negedge clk) begin
        if (rst_n && upd_pulse) begin
            pulses++;
            if (expq.size() == 0) begin
                chk(1'b0, "R4", "unexpected strobe", 1, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk(dac_code == e.code, "R3 R9", "code", dac_code, e.code);
                chk(pd_mode == e.mode, "R3", "mode", pd_mode, e.mode);
                chk(drv_now() == drv_of(e.mode), "R5", "drive", drv_now(), drv_of(e.mode));
            end
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bits(input logic [15:0] w, input int nbits);
        for (int i = 15; i > 15 - nbits; i--) begin
            sdi = w[i];
            wclk(4);
            sck = 1'b0;
            wclk(4);
            sck = 1'b1;
        end
    endtask

    // driver: re-arm select, send a full word, leave select low
    task automatic send_word(input logic [15:0] w);
        exp_t e;
        sel_n = 1'b1;
        wclk(8);
        sel_n = 1'b0;
        wclk(6);
        e.code = w[11:4];
        e.mode = w[13:12];
        expq.push_back(e);
        pushed++;
        send_bits(w, 16);
        wclk(12);
        // R4: applied while select is still low
        chk(expq.size() == 0, "R4", "applied with select low", expq.size(), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sel_n = 1'b1; sck = 1'b1; sdi = 1'b0;
        wclk(5);
        chk(dac_code == 8'h00, "R1", "reset code", dac_code, 0);
        chk(pd_mode == 2'b00, "R1", "reset mode", pd_mode, 0);
        chk(drv_now() == 4'b0001, "R1", "reset drive", drv_now(), 1);
        chk(upd_pulse == 1'b0, "R1", "reset strobe", upd_pulse, 0);
        rst_n = 1'b1;
        wclk(6);
        chk(dac_code == 8'h00 && pd_mode == 2'b00, "R1", "after release", dac_code, 0);

        send_word(16'h2A50);   // mode 10, code A5
        send_word(16'h0FF0);   // mode 00, code FF (R9 top)
        send_word(16'h1000);   // mode 01, code 00 (R9 bottom)
        send_word(16'h3550);   // mode 11, code 55
        send_word(16'hC00F);   // R8: ignored bits set, mode 00, code 00
        send_word(16'hF7EF);   // R8: mode 11, code 7E
        chk(dac_code == 8'h7E && pd_mode == 2'b11, "R8", "ignored bits", dac_code, 8'h7E);

        // R6: ten bits then select high
        sel_n = 1'b1; wclk(8); sel_n = 1'b0; wclk(6);
        send_bits(16'h0FF0, 10);
        sel_n = 1'b1;
        wclk(30);
        chk(dac_code == 8'h7E, "R6", "code after abort", dac_code, 8'h7E);
        chk(pd_mode == 2'b11, "R6", "mode after abort", pd_mode, 2'b11);
        chk(pulses == pushed, "R6", "strobes after abort", pulses, pushed);

        // R7 / R2: complete word, then more clocks without re-arm
        send_word(16'h1120);   // mode 01, code 12
        send_bits(16'h2FF0, 16);
        wclk(30);
        chk(dac_code == 8'h12, "R7", "code after extra clocks", dac_code, 8'h12);
        chk(pd_mode == 2'b01, "R7", "mode after extra clocks", pd_mode, 2'b01);
        chk(drv_now() == 4'b0010, "R7", "drive after extra clocks", drv_now(), 4'b0010);
        chk(pulses == pushed, "R2", "strobes without re-arm", pulses, pushed);

        send_word(16'h2340);   // fresh select cycle accepted: mode 10, code 34
        sel_n = 1'b1;
        wclk(20);
        chk(dac_code == 8'h34 && pd_mode == 2'b10, "R2", "after re-arm", dac_code, 8'h34);
        chk(expq.size() == 0, "R4", "scoreboard drained", expq.size(), 0);
        chk(pulses == pushed, "R4", "strobe count", pulses, pushed);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule